// File: doc/BRIEF.md
# Quad DAC Serial Load Controller

This block is the digital front end of a four-channel 8-bit converter. A host shifts 12-bit words in over a serial data line and a serial clock, gated by an enable line. The block decodes each word and keeps, for every channel, a pending input register and an output register. Each register holds an 8-bit code and a range flag that picks an output gain of one or two. The output registers drive the converter cores, which are outside this block.

All three serial lines are asynchronous to the block. Each one passes through a synchronizer clocked by a fast system clock, and the serial clock's falling edge is found from the synchronized copy. Two transfer schemes are available. In double-buffered operation, which is active after reset, words fill only the input registers, and all outputs copy them together when enable falls. This lets several converters share data and clock lines, each with its own enable. In single-buffered operation, every data word reaches its output as soon as the word completes, so enable can be tied high.

With enable tied high, noise can leave the link out of step with word boundaries. A run of twelve consecutive zero bits restores alignment.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: A word is 12 bits, shifted in MSB first. One bit is taken on each falling edge of the serial clock while enable is high.
- R2: While enable is low, serial clock edges are ignored and no register changes. If enable falls partway through a word, the partial bits are discarded, and the next word starts at its first bit.
- R3: After reset, all four output codes and range flags are 0, and the block is in double-buffered operation.
- R4: In double-buffered operation, a data word changes only an input register. All four outputs take their input register values on the falling edge of enable.
- R5: Data word layout: bit 11 = 0, bits 10:9 select the channel (0 = A, 1 = B, 2 = C, 3 = D), bit 8 is the range flag, and bits 7:0 are the code.
- R6: A control word has bit 11 = 1. If its bit 0 is 1, it selects single-buffered operation and copies all input registers to the outputs when the word ends. If bit 0 is 0, it changes nothing. Bits 10:1 of a control word are ignored.
- R7: In single-buffered operation, a data word updates its channel's output at the end of the word, without waiting for enable to fall.
- R8: Once single-buffered operation is selected, it stays selected until reset. A control word with bit 0 = 0 does not return the block to double-buffered operation.
- R9: Twelve consecutive zero bits received while enable is high reset the bit position and cause no register write. The next bit is then the first bit of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data, asynchronous |
| sclk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| sen_i | input | 1 | Serial enable; its falling edge triggers the double-buffered transfer |
| code_o | output | 32 | Output codes; channel n is at bits [8n+7:8n] |
| range_o | output | 4 | Output range flags, bit n for channel n |

## Verification
The bit counter and the zero-run counter are never visible directly. If either one is wrong, every later word lands shifted by one or more bits. The fault then shows at the outputs on the next transfer, as a write to the wrong channel or a wrong code. The mode bit shows its state through timing alone. Whether an output moves before or only after enable falls reveals a mode error within one word. The directed cases therefore check the outputs both just before and just after each enable fall.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned NCH_DEF    = 4;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_CTRL = 1'b1
  } word_kind_e;
endpackage

// File: rtl/qdac_in_sync.sv
module qdac_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/qdac_word_rx.sv
module qdac_word_rx #(
  parameter int unsigned WORD_W   = 12,
  parameter int unsigned ZERO_RUN = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam int unsigned ZC_W  = $clog2(ZERO_RUN + 1);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ZC_W-1:0]   zc_q;
  logic              vld_q;
  logic              resync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      zc_q     <= '0;
      vld_q    <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      vld_q    <= 1'b0;
      resync_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
        zc_q  <= '0;
      end else if (bit_stb_i) begin
        shift_q <= {shift_q[WORD_W-2:0], bit_i};
        if (!bit_i && zc_q == ZC_W'(ZERO_RUN - 1)) begin
          // zero run complete: realign, suppress any write
          zc_q     <= '0;
          cnt_q    <= '0;
          resync_q <= 1'b1;
        end else begin
          zc_q <= bit_i ? '0 : zc_q + 1'b1;
          if (cnt_q == CNT_W'(WORD_W - 1)) begin
            cnt_q <= '0;
            vld_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = shift_q;

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WORD_W));
  a_r1_word_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(bit_stb_i && en_i));
  a_r2_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !vld_q));
  a_r9_resync_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_q |-> (!vld_q && cnt_q == '0));
endmodule

// File: rtl/qdac_chan_regs.sv
module qdac_chan_regs #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned SEL_W  = $clog2(NCH),
  parameter int unsigned WORD_W = 2 + SEL_W + CODE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           word_vld_i,
  input  logic [WORD_W-1:0]              word_i,
  input  logic                           en_fall_i,
  output logic [NCH-1:0][CODE_W:0]       out_o
);
  import qdac_pkg::*;

  localparam int unsigned KIND_BIT = WORD_W - 1;

  logic [NCH-1:0][CODE_W:0] in_q, in_nxt, out_q;
  logic                     mode_q;
  logic                     is_ctrl, wr_data, set_mode, xfer_all;
  logic [SEL_W-1:0]         sel;
  logic [CODE_W:0]          payload;

  assign is_ctrl  = word_kind_e'(word_i[KIND_BIT]) == KIND_CTRL;
  assign sel      = word_i[KIND_BIT-1 -: SEL_W];
  assign payload  = word_i[CODE_W:0];
  assign wr_data  = word_vld_i && !is_ctrl;
  assign set_mode = word_vld_i && is_ctrl && word_i[0];
  assign xfer_all = set_mode || (en_fall_i && !mode_q);

  always_comb begin
    in_nxt = in_q;
    if (wr_data) in_nxt[sel] = payload;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      out_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      in_q   <= in_nxt;
      mode_q <= mode_q | set_mode;
      if (xfer_all)               out_q      <= in_nxt;
      else if (mode_q && wr_data) out_q[sel] <= payload;
    end
  end

  assign out_o = out_q;

  a_r8_mode_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q);
  a_r4_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !en_fall_i && !set_mode) |=> $stable(out_q));
  a_r4_fall_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_fall_i && !mode_q) |=> (out_q == in_q));
  a_r6_enter_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_mode |=> (mode_q && out_q == in_q));
  a_r7_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && wr_data) |=> (out_q[$past(sel)] == $past(payload)));
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl #(
  parameter int unsigned NCH         = qdac_pkg::NCH_DEF,
  parameter int unsigned CODE_W      = qdac_pkg::CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = qdac_pkg::SYNC_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sdata_i,
  input  logic                  sclk_i,
  input  logic                  sen_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        range_o
);
  localparam int unsigned SEL_W  = $clog2(NCH);
  localparam int unsigned WORD_W = 2 + SEL_W + CODE_W;
  localparam int unsigned NIN    = 3;

  logic [NIN-1:0] raw_in, sync_in;
  logic           data_s, sclk_s, en_s;
  logic           sclk_d_q, en_d_q;
  logic           sclk_fall, en_fall, bit_stb;
  logic                     word_vld;
  logic [WORD_W-1:0]        word;
  logic [NCH-1:0][CODE_W:0] chan_out;

  assign raw_in = {sen_i, sclk_i, sdata_i};

  generate
    for (genvar i = 0; i < NIN; i++) begin : g_sync
      qdac_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_in[i]),
        .q_o   (sync_in[i])
      );
    end
  endgenerate

  assign {en_s, sclk_s, data_s} = sync_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      en_d_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      en_d_q   <= en_s;
    end
  end

  assign sclk_fall = sclk_d_q && !sclk_s;
  assign en_fall   = en_d_q && !en_s;
  assign bit_stb   = sclk_fall && en_s;

  qdac_word_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_s),
    .bit_stb_i (bit_stb),
    .bit_i     (data_s),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  qdac_chan_regs #(
    .NCH   (NCH),
    .CODE_W(CODE_W),
    .SEL_W (SEL_W),
    .WORD_W(WORD_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_vld_i(word_vld),
    .word_i    (word),
    .en_fall_i (en_fall),
    .out_o     (chan_out)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_out
      assign code_o[ch*CODE_W +: CODE_W] = chan_out[ch][CODE_W-1:0];
      assign range_o[ch]                 = chan_out[ch][CODE_W];
    end
  endgenerate
endmodule

// File: tb/qdac_serial_ctrl_tb.sv
module qdac_serial_ctrl_tb;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdata = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [31:0] code;
  logic [3:0]  rng;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_code [4];
  logic       exp_rng  [4];
  logic [7:0] pend_code [4];
  logic       pend_rng  [4];

  always #2 clk = ~clk;

  qdac_serial_ctrl u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sdata_i(sdata),
    .sclk_i (sclk),
    .sen_i  (sen),
    .code_o (code),
    .range_o(rng)
  );

  function automatic logic [11:0] dword(input int ch, input logic r, input logic [7:0] c);
    dword = {1'b0, 2'(ch), r, c};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic set_en(input logic v);
    sen = v;
    wait_clk(HALF);
  endtask

  task automatic latch_pending(input int ch, input logic r, input logic [7:0] c);
    pend_code[ch] = c;
    pend_rng[ch]  = r;
  endtask

  task automatic xfer_pending();
    for (int ch = 0; ch < 4; ch++) begin
      exp_code[ch] = pend_code[ch];
      exp_rng[ch]  = pend_rng[ch];
    end
  endtask

  task automatic check_all(input string req);
    for (int ch = 0; ch < 4; ch++) begin
      checks++;
      if (code[ch*8 +: 8] !== exp_code[ch] || rng[ch] !== exp_rng[ch]) begin
        fails++;
        $display("FAIL %s ch%0d: got code=%02h range=%0b, expected code=%02h range=%0b",
                 req, ch, code[ch*8 +: 8], rng[ch], exp_code[ch], exp_rng[ch]);
      end
    end
  endtask

  // R3: reset state
  task automatic t_reset();
    for (int ch = 0; ch < 4; ch++) begin
      exp_code[ch] = '0; exp_rng[ch] = 1'b0;
      pend_code[ch] = '0; pend_rng[ch] = 1'b0;
    end
    check_all("R3");
  endtask

  // R1 R4 R5: double-buffered load, outputs move only on enable fall
  task automatic t_double();
    set_en(1'b1);
    send_word(dword(0, 1'b1, 8'h5A)); latch_pending(0, 1'b1, 8'h5A);
    check_all("R4");
    set_en(1'b0); xfer_pending();
    check_all("R1");
    set_en(1'b1);
    send_word(dword(1, 1'b0, 8'hC3)); latch_pending(1, 1'b0, 8'hC3);
    send_word(dword(3, 1'b1, 8'h01)); latch_pending(3, 1'b1, 8'h01);
    check_all("R4");
    set_en(1'b0); xfer_pending();
    check_all("R5");
  endtask

  // R2: partial word dropped when enable falls
  task automatic t_abort();
    set_en(1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    set_en(1'b0); xfer_pending();
    check_all("R2");
    set_en(1'b1);
    send_word(dword(2, 1'b0, 8'h77)); latch_pending(2, 1'b0, 8'h77);
    set_en(1'b0); xfer_pending();
    check_all("R2");
  endtask

  // R2: clock edges ignored with enable low
  task automatic t_disabled();
    send_word(dword(1, 1'b1, 8'hEE));
    set_en(1'b1);
    set_en(1'b0); xfer_pending();
    check_all("R2");
  endtask

  // R6: control word with bit0 = 0 is a no-op
  task automatic t_ctrl_noop();
    set_en(1'b1);
    send_word(12'h810);
    send_word(dword(0, 1'b0, 8'h33)); latch_pending(0, 1'b0, 8'h33);
    check_all("R6");
    set_en(1'b0); xfer_pending();
    check_all("R6");
  endtask

  // R6: entering single mode transfers pending inputs at end of control word
  task automatic t_enter_single();
    set_en(1'b1);
    send_word(dword(2, 1'b1, 8'h9C)); latch_pending(2, 1'b1, 8'h9C);
    check_all("R6");
    send_word(12'h801); xfer_pending();
    check_all("R6");
    set_en(1'b0);
    check_all("R6");
  endtask

  // R7 R8: single-buffered update and sticky mode
  task automatic t_single();
    set_en(1'b1);
    send_word(dword(3, 1'b0, 8'h42)); latch_pending(3, 1'b0, 8'h42); xfer_pending();
    check_all("R7");
    send_word(12'h810);
    send_word(dword(0, 1'b1, 8'hA5)); latch_pending(0, 1'b1, 8'hA5); xfer_pending();
    check_all("R8");
    set_en(1'b0);
    check_all("R8");
  endtask

  // R9: twelve zeros realign a permanently enabled link
  task automatic t_resync();
    set_en(1'b1);
    // garbage forms word 0_10_1_10000000 (ch C), then 5 more zeros
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < 12; i++) send_bit(1'b0);
    latch_pending(2, 1'b1, 8'h80); xfer_pending();
    check_all("R9");
    send_word(dword(1, 1'b1, 8'h6D)); latch_pending(1, 1'b1, 8'h6D); xfer_pending();
    check_all("R9");
    set_en(1'b0);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_ni = 1'b1;
    wait_clk(5);
    t_reset();
    t_double();
    t_abort();
    t_disabled();
    t_ctrl_noop();
    t_enter_single();
    t_single();
    t_resync();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule